// File: doc/BRIEF.md
# CAN Bus-Off Recovery and Control Unit

This block sits beside a CAN protocol engine. It holds the control word that software writes: initialization, three interrupt enables, retransmission disable, configuration-change enable and test enable. From that word and the engine's status strobes it drives an active-low interrupt line. It also guards software writes to the bit-timing register, which are allowed only while the controller is being configured.

When the engine reports entry into bus-off, the block sets initialization on its own and takes the bus offline. Software must later clear initialization. After that, the block watches the received bit stream at each sample point and counts runs of 11 recessive bits. When the 129th run is seen, it issues a one-cycle clear to the engine's error counters. Toggling initialization during this wait neither cuts it short nor restarts it.

The received bits arrive as a sample strobe with a bit value. Every input is a plain level or a one-cycle strobe, so there is no valid/ready handshake and no back-pressure. The block accepts a bit on every cycle in which the strobe is high.

Top module: `can_busoff_ctrl`

## Requirements
- R1: After reset, the control word reads 0x00000001, irq_n is 1, recov_active and err_cnt_clr are 0, and bit_timing holds BT_RST.
- R2: The control word bit layout is: bit 0 initialization, bit 1 module interrupt enable, bit 2 status interrupt enable, bit 3 error interrupt enable, bit 5 retransmission disable, bit 6 configuration-change enable, bit 7 test enable. Bit 4 and bits 31:8 ignore writes and read 0, so writing all ones reads back 0x000000EF.
- R3: On the first cycle that eng_busoff is sampled high after being low, bit 0 of the control word is 1 on the following cycle, even if the CPU writes 0 to it in that same cycle. recov_active also rises on that cycle.
- R4: While counting, a recessive sample (rx_bit=1) lengthens the current run and a dominant sample resets it to zero. Eleven consecutive recessive samples form one idle event, and the next run then starts at zero.
- R5: err_cnt_clr is high for exactly one cycle. It rises on the cycle after the strobe that completes the 129th idle event following the release of initialization. recov_active falls in that same cycle.
- R6: No idle events are counted while initialization is still set after bus-off entry. Once counting has begun, setting and clearing initialization neither restarts the count nor shortens it.
- R7: irq_n is 0 when bit 1 is set and an interrupt is pending. irq_n is 1 whenever bit 1 is clear. Pending state is kept while bit 1 is clear.
- R8: A status interrupt becomes pending on eng_tx_ok or eng_bus_err only when bit 2 is set. It stays pending until stat_irq_clr is pulsed.
- R9: An error interrupt becomes pending on any change of eng_busoff or eng_ewarn only when bit 3 is set. It stays pending until err_irq_clr is pulsed.
- R10: A bit-timing write takes effect only while bits 0 and 6 of the control word are both 1. In any other state the register keeps its value.
- R11: bus_enable is 1 exactly when initialization is 0 and no recovery is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ctrl_wr | input | 1 | Control word write strobe |
| cpu_ctrl_wdata | input | CPU_W | Control word write data |
| ctrl_word | output | CPU_W | Control word readback |
| cpu_bt_wr | input | 1 | Bit-timing write strobe |
| cpu_bt_wdata | input | BT_W | Bit-timing write data |
| bit_timing | output | BT_W | Bit-timing register value |
| eng_busoff | input | 1 | Engine bus-off status level |
| eng_ewarn | input | 1 | Engine error-warning status level |
| eng_tx_ok | input | 1 | Successful transfer strobe |
| eng_bus_err | input | 1 | Bus error detected strobe |
| smp_strb | input | 1 | Sample-point strobe |
| rx_bit | input | 1 | Received bit, 1 = recessive |
| stat_irq_clr | input | 1 | Clear pending status interrupt |
| err_irq_clr | input | 1 | Clear pending error interrupt |
| irq_n | output | 1 | Active-low interrupt line |
| stat_pend | output | 1 | Status interrupt pending |
| err_pend | output | 1 | Error interrupt pending |
| bus_enable | output | 1 | Engine may take part in bus activity |
| recov_active | output | 1 | Bus-off recovery in progress |
| err_cnt_clr | output | 1 | One-cycle error counter clear |
| retx_disable | output | 1 | Automatic retransmission disabled |
| test_mode | output | 1 | Test mode enabled |

## Verification
The bench builds the block with its default parameters: runs of 11 recessive bits, 129 idle events and a 16-bit timing register. At these values the full recovery wait of over 1400 sample strobes fits easily in one run, so the exact cycle of the counter clear is checked against the true event count. The stimulus is chosen to catch specific faults. Strobes sent before release would count early. A dominant bit placed just before a run completes would be missed if the run were not reset. An initialization toggle halfway through would restart the wait. The scoreboard expects one clear at one computed cycle, so any of these faults makes the clear arrive early, late or more than once.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;

  // Control byte, bit 7 down to bit 0
  typedef struct packed {
    logic test_en;
    logic cfg_en;
    logic retx_off;
    logic rsvd4;
    logic err_ie;
    logic stat_ie;
    logic irq_en;
    logic init;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_COUNT = 2'd2
  } seq_state_t;

  localparam logic [7:0] CTRL_RST   = 8'h01;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;

endpackage

// File: rtl/can_bor_ctrl_reg.sv
module can_bor_ctrl_reg
  import can_bor_pkg::*;
#(
  parameter int CPU_W = 32,
  parameter int BT_W = 16,
  parameter logic [BT_W-1:0] BT_RST = 16'h2301
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [CPU_W-1:0] cpu_wdata,
  input  logic             force_init,
  input  logic             bt_wr,
  input  logic [BT_W-1:0]  bt_wdata,
  output ctrl_t            ctrl,
  output logic [BT_W-1:0]  bt_q
);

  logic unused_hi;
  assign unused_hi = ^cpu_wdata[CPU_W-1:8];

  logic bt_open;
  assign bt_open = ctrl.init && ctrl.cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= ctrl_t'(CTRL_RST);
    end else begin
      if (cpu_wr) ctrl <= ctrl_t'(cpu_wdata[7:0] & CTRL_WMASK);
      // bus-off entry wins over a software write in the same cycle
      if (force_init) ctrl.init <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bt_q <= BT_RST;
    else if (bt_wr && bt_open) bt_q <= bt_wdata;
  end

  a_r10_bt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.init && ctrl.cfg_en) |=> $stable(bt_q));

  a_r3_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_init |=> ctrl.init);

endmodule

// File: rtl/can_bor_idle_det.sv
module can_bor_idle_det #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic smp_strb,
  input  logic rx_bit,
  output logic idle_evt
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      run <= '0;
    end else if (smp_strb) begin
      if (!rx_bit || run == LAST) run <= '0;
      else run <= run + 1'b1;
    end
  end

  assign idle_evt = enable && smp_strb && rx_bit && (run == LAST);

  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= LAST);

  a_r4_dominant_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && smp_strb && !rx_bit) |-> !idle_evt);

endmodule

// File: rtl/can_bor_seq.sv
module can_bor_seq
  import can_bor_pkg::*;
#(
  parameter int EVENTS = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff,
  input  logic init,
  input  logic idle_evt,
  output logic force_init,
  output logic count_en,
  output logic recov_active,
  output logic cnt_clr
);

  localparam int EV_W = $clog2(EVENTS + 1);
  localparam logic [EV_W-1:0] EV_LAST = EV_W'(EVENTS - 1);

  seq_state_t       state;
  logic [EV_W-1:0]  evcnt;
  logic             busoff_q;
  logic             entry;

  assign entry      = busoff && !busoff_q;
  assign force_init = entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      evcnt    <= '0;
      busoff_q <= 1'b0;
      cnt_clr  <= 1'b0;
    end else begin
      busoff_q <= busoff;
      cnt_clr  <= 1'b0;
      if (entry) begin
        state <= SEQ_HOLD;
        evcnt <= '0;
      end else begin
        unique case (state)
          SEQ_HOLD:  if (!init) state <= SEQ_COUNT;
          SEQ_COUNT: if (idle_evt) begin
            if (evcnt == EV_LAST) begin
              state   <= SEQ_IDLE;
              evcnt   <= '0;
              cnt_clr <= 1'b1;
            end else begin
              evcnt <= evcnt + 1'b1;
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign count_en     = (state == SEQ_COUNT);
  assign recov_active = (state != SEQ_IDLE);

  a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);

  a_r6_hold_while_init: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_HOLD && init) |=> state == SEQ_HOLD);

  a_r6_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_COUNT && !idle_evt && !entry) |=> $stable(evcnt) && state == SEQ_COUNT);

endmodule

// File: rtl/can_bor_irq.sv
module can_bor_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic stat_ie,
  input  logic err_ie,
  input  logic tx_ok,
  input  logic bus_err,
  input  logic stat_clr,
  input  logic err_clr,
  input  logic busoff,
  input  logic ewarn,
  output logic irq_n,
  output logic stat_pend,
  output logic err_pend
);

  logic busoff_p, ewarn_p;
  logic stat_set, err_set;

  assign stat_set = stat_ie && (tx_ok || bus_err);
  assign err_set  = err_ie && ((busoff ^ busoff_p) || (ewarn ^ ewarn_p));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busoff_p  <= 1'b0;
      ewarn_p   <= 1'b0;
      stat_pend <= 1'b0;
      err_pend  <= 1'b0;
    end else begin
      busoff_p <= busoff;
      ewarn_p  <= ewarn;
      if (stat_set)      stat_pend <= 1'b1;
      else if (stat_clr) stat_pend <= 1'b0;
      if (err_set)       err_pend  <= 1'b1;
      else if (err_clr)  err_pend  <= 1'b0;
    end
  end

  assign irq_n = !(irq_en && (stat_pend || err_pend));

  a_r8_stat_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ie && !stat_pend) |=> !stat_pend);

  a_r9_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ie && !err_pend) |=> !err_pend);

endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl
  import can_bor_pkg::*;
#(
  parameter int CPU_W = 32,
  parameter int BT_W = 16,
  parameter logic [BT_W-1:0] BT_RST = 16'h2301,
  parameter int RUN_LEN = 11,
  parameter int EVENTS = 129
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ctrl_wr,
  input  logic [CPU_W-1:0] cpu_ctrl_wdata,
  output logic [CPU_W-1:0] ctrl_word,
  input  logic             cpu_bt_wr,
  input  logic [BT_W-1:0]  cpu_bt_wdata,
  output logic [BT_W-1:0]  bit_timing,
  input  logic             eng_busoff,
  input  logic             eng_ewarn,
  input  logic             eng_tx_ok,
  input  logic             eng_bus_err,
  input  logic             smp_strb,
  input  logic             rx_bit,
  input  logic             stat_irq_clr,
  input  logic             err_irq_clr,
  output logic             irq_n,
  output logic             stat_pend,
  output logic             err_pend,
  output logic             bus_enable,
  output logic             recov_active,
  output logic             err_cnt_clr,
  output logic             retx_disable,
  output logic             test_mode
);

  ctrl_t ctrl;
  logic  force_init, count_en, idle_evt;

  can_bor_ctrl_reg #(.CPU_W(CPU_W), .BT_W(BT_W), .BT_RST(BT_RST)) u_reg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_ctrl_wr), .cpu_wdata(cpu_ctrl_wdata),
    .force_init(force_init), .bt_wr(cpu_bt_wr), .bt_wdata(cpu_bt_wdata),
    .ctrl(ctrl), .bt_q(bit_timing)
  );

  can_bor_idle_det #(.RUN_LEN(RUN_LEN)) u_idle (
    .clk(clk), .rst_n(rst_n), .enable(count_en), .smp_strb(smp_strb),
    .rx_bit(rx_bit), .idle_evt(idle_evt)
  );

  can_bor_seq #(.EVENTS(EVENTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .busoff(eng_busoff), .init(ctrl.init),
    .idle_evt(idle_evt), .force_init(force_init), .count_en(count_en),
    .recov_active(recov_active), .cnt_clr(err_cnt_clr)
  );

  can_bor_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_en(ctrl.irq_en), .stat_ie(ctrl.stat_ie),
    .err_ie(ctrl.err_ie), .tx_ok(eng_tx_ok), .bus_err(eng_bus_err),
    .stat_clr(stat_irq_clr), .err_clr(err_irq_clr), .busoff(eng_busoff),
    .ewarn(eng_ewarn), .irq_n(irq_n), .stat_pend(stat_pend), .err_pend(err_pend)
  );

  assign ctrl_word    = {{(CPU_W-8){1'b0}}, ctrl};
  assign bus_enable   = !ctrl.init && !recov_active;
  assign retx_disable = ctrl.retx_off;
  assign test_mode    = ctrl.test_en;

  a_r3_busoff_sets_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busoff) |=> ctrl_word[0] && recov_active);

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[1] |-> irq_n);

  a_r5_clr_ends_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_clr |-> !recov_active);

endmodule

// File: tb/tb_can_busoff_ctrl.sv
module tb_can_busoff_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_ctrl_wr;
  logic [31:0] cpu_ctrl_wdata;
  logic [31:0] ctrl_word;
  logic        cpu_bt_wr;
  logic [15:0] cpu_bt_wdata;
  logic [15:0] bit_timing;
  logic        eng_busoff, eng_ewarn, eng_tx_ok, eng_bus_err;
  logic        smp_strb, rx_bit, stat_irq_clr, err_irq_clr;
  logic        irq_n, stat_pend, err_pend, bus_enable, recov_active;
  logic        err_cnt_clr, retx_disable, test_mode;

  int n_tests = 0;
  int n_fail  = 0;
  int unsigned cyc = 0;
  int unsigned exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_busoff_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_ctrl_wr(cpu_ctrl_wr), .cpu_ctrl_wdata(cpu_ctrl_wdata),
    .ctrl_word(ctrl_word), .cpu_bt_wr(cpu_bt_wr), .cpu_bt_wdata(cpu_bt_wdata),
    .bit_timing(bit_timing), .eng_busoff(eng_busoff), .eng_ewarn(eng_ewarn),
    .eng_tx_ok(eng_tx_ok), .eng_bus_err(eng_bus_err), .smp_strb(smp_strb),
    .rx_bit(rx_bit), .stat_irq_clr(stat_irq_clr), .err_irq_clr(err_irq_clr),
    .irq_n(irq_n), .stat_pend(stat_pend), .err_pend(err_pend),
    .bus_enable(bus_enable), .recov_active(recov_active), .err_cnt_clr(err_cnt_clr),
    .retx_disable(retx_disable), .test_mode(test_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    cpu_ctrl_wr = 1'b1; cpu_ctrl_wdata = v;
    tick();
    cpu_ctrl_wr = 1'b0;
  endtask

  task automatic wr_bt(logic [15:0] v);
    cpu_bt_wr = 1'b1; cpu_bt_wdata = v;
    tick();
    cpu_bt_wr = 1'b0;
  endtask

  task automatic bits(logic b, int n);
    smp_strb = 1'b1; rx_bit = b;
    repeat (n) tick();
    smp_strb = 1'b0; rx_bit = 1'b1;
  endtask

  // scoreboard driver side: the clear is due on the edge after n more edges
  task automatic expect_clear(int n);
    exp_q.push_back(cyc + n);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rst_n === 1'b1 && err_cnt_clr === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R5: actual clear at cycle %0d expected none", cyc);
      end else begin
        check("R5 clear cycle", cyc, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_ctrl_wr = 0; cpu_ctrl_wdata = 0; cpu_bt_wr = 0; cpu_bt_wdata = 0;
    eng_busoff = 0; eng_ewarn = 0; eng_tx_ok = 0; eng_bus_err = 0;
    smp_strb = 0; rx_bit = 1; stat_irq_clr = 0; err_irq_clr = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 ctrl", ctrl_word, 32'h1);
    check("R1 irq_n", irq_n, 1);
    check("R1 recov", recov_active, 0);
    check("R1 clr", err_cnt_clr, 0);
    check("R1 bt", bit_timing, 32'h2301);
    check("R11 init blocks bus", bus_enable, 0);

    // R2 layout and reserved bits
    wr_ctrl(32'hFFFF_FFFF);
    check("R2 all ones", ctrl_word, 32'hEF);
    check("R2 retx", retx_disable, 1);
    check("R2 test", test_mode, 1);
    wr_ctrl(32'h0);
    check("R2 zero", ctrl_word, 32'h0);
    check("R11 bus on", bus_enable, 1);

    // R10 bit-timing gate
    wr_ctrl(32'h41);
    wr_bt(16'h1234);
    check("R10 open", bit_timing, 32'h1234);
    wr_ctrl(32'h01);
    wr_bt(16'h5555);
    check("R10 no cfg_en", bit_timing, 32'h1234);
    wr_ctrl(32'h40);
    wr_bt(16'hAAAA);
    check("R10 no init", bit_timing, 32'h1234);

    // R8 / R7 status interrupts
    wr_ctrl(32'h02);
    eng_tx_ok = 1; tick(); eng_tx_ok = 0;
    check("R8 gated by sie", irq_n, 1);
    wr_ctrl(32'h06);
    eng_tx_ok = 1; tick(); eng_tx_ok = 0;
    check("R8 tx sets", irq_n, 0);
    wr_ctrl(32'h04);
    check("R7 masked", irq_n, 1);
    wr_ctrl(32'h06);
    check("R7 pending kept", irq_n, 0);
    stat_irq_clr = 1; tick(); stat_irq_clr = 0;
    check("R8 clear", irq_n, 1);
    eng_bus_err = 1; tick(); eng_bus_err = 0;
    check("R8 bus err sets", stat_pend, 1);
    stat_irq_clr = 1; tick(); stat_irq_clr = 0;

    // R9 error interrupts
    wr_ctrl(32'h02);
    eng_ewarn = 1; tick();
    check("R9 gated by eie", irq_n, 1);
    wr_ctrl(32'h0A);
    eng_ewarn = 0; tick();
    check("R9 fall sets", irq_n, 0);
    err_irq_clr = 1; tick(); err_irq_clr = 0;
    check("R9 clear", irq_n, 1);
    eng_ewarn = 1; tick();
    check("R9 rise sets", err_pend, 1);
    err_irq_clr = 1; tick(); err_irq_clr = 0;
    eng_ewarn = 0;
    wr_ctrl(32'h0);
    tick();

    // R3 bus-off entry overrides a same-cycle write
    cpu_ctrl_wr = 1; cpu_ctrl_wdata = 32'h0; eng_busoff = 1;
    tick();
    cpu_ctrl_wr = 0;
    check("R3 init forced", ctrl_word[0], 1);
    check("R3 recov", recov_active, 1);
    check("R11 bus off", bus_enable, 0);

    // R6 strobes before release do not count
    bits(1, 30);
    wr_ctrl(32'h0);
    tick();
    check("R11 still recovering", bus_enable, 0);

    // R4 dominant bit breaks a run of 10
    bits(1, 10);
    bits(0, 1);
    bits(1, 11 * 50);
    // R6 toggle init mid-count
    wr_ctrl(32'h1);
    wr_ctrl(32'h0);
    tick();
    check("R6 recov kept", recov_active, 1);
    bits(1, 11 * 79 - 1);
    check("R5 not early", err_cnt_clr, 0);
    check("R6 not shortened", recov_active, 1);
    expect_clear(1);
    bits(1, 1);
    check("R5 clear pulse", err_cnt_clr, 1);
    check("R5 recov ends", recov_active, 0);
    tick();
    check("R5 single cycle", err_cnt_clr, 0);
    eng_busoff = 0;
    tick();
    check("R11 bus resumes", bus_enable, 1);
    check("R5 queue drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule